// File: doc/BRIEF.md
# Serial Port Bit-Clock and Frame-Sync Generator

This block derives a bit clock and a periodic frame-sync pulse from the system clock for a serial port. A single control bit with negative polarity, writable and readable through a one-bit register port, holds the generator in reset (0) or lets it run (1). While the bit is 0, the outputs depend on why it is 0. After a system reset the bit clock keeps toggling at half the system rate. After software clears the bit, both outputs are held low.

When running, the bit clock divides the system clock by a programmable ratio. A frame-sync pulse one bit-clock period wide is issued every programmable number of bit-clock periods, but only while the separate frame-sync enable input is high. Each time the bit goes from 0 to 1, the divider and the frame counter restart from zero, so the first output edge lands at a fixed point after the write.

Top module: `srg_top`

## Requirements
- R1: While system reset is low, and on every edge it is sampled low, the control bit reads 0 and both outputs are 0. A read returns 1 only while the generator runs.
- R2: After a system reset, until the first write, `clk_out` inverts on every system clock edge (high on the first edge after reset is released) and `fs_out` stays 0.
- R3: When 0 is written while running (write seen at edge E), the read value is 0 after E. From edge E+1 on, `clk_out` and `fs_out` are both 0.
- R4: When 1 is written from either hold state (write seen at edge E), the read value is 1 after E. At edge E+1+k, `clk_out` equals ((k mod N) < H), with N = `clk_div`+1 and H = floor(N/2).
- R5: For odd N, the high phase is one system clock shorter than the low phase. For N = 1 (`clk_div` = 0), H is taken as 1, so `clk_out` stays high.
- R6: At edge E+1+k, with p = floor(k/N), `fs_out` is 1 exactly when the enable input sampled at that edge is 1 and p mod (`frame_per`+1) = 0.
- R7: With `fs_en` at 0, `fs_out` is 0 after the next edge, whatever the generator state.
- R8: Writing 1 while already running neither restarts nor disturbs the divider or frame phase.
- R9: Writing 0 while in the post-system-reset hold stops the half-rate clock. From the second edge after the write, both outputs are held at 0.
- R10: With `frame_per` = 0, `fs_out` stays at 1 for every running cycle while `fs_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| wr_en | input | 1 | Write strobe for the control bit |
| wr_data | input | 1 | Value written to the control bit (0 hold, 1 run) |
| rd_data | output | 1 | Current control bit value |
| clk_div | input | 8 | Divide ratio minus one |
| frame_per | input | 12 | Frame period in bit-clock periods, minus one |
| fs_en | input | 1 | Frame-sync enable |
| clk_out | output | 1 | Generated bit clock |
| fs_out | output | 1 | Generated frame-sync pulse |

## Verification
A wrong hold mode appears within two edges: a half-rate toggle where a flat low level belongs, or the reverse. A read value that does not match the behaviour of the outputs also exposes it. A divider counter that is off by one shifts the phase of `clk_out`, and that shows within one divide period after the restart. A frame counter error moves or stretches the `fs_out` pulse by whole bit-clock periods, and that shows within one frame. A bad wrap or a restart on a redundant write only shows once the following frames are compared.

// File: rtl/srg_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the bit-clock / frame-sync generator.
// Assumes: nothing beyond IEEE 1800-2017.
package srg_pkg;

    // Generator operating state; the hold cause is kept distinct.
    typedef enum logic [1:0] {
        SRG_SYS_HOLD = 2'd0,
        SRG_SW_HOLD  = 2'd1,
        SRG_RUN      = 2'd2
    } srg_mode_e;

endpackage

// File: rtl/srg_ctrl.sv
`timescale 1ns/1ps
// Module: srg_ctrl
// Holds the negative-polarity run bit together with the cause of the
// last hold. System reset gives the system-hold state. A write of 0 gives
// the software-hold state. A write of 1 starts or keeps the run state.
// Assumes: rst_n is synchronous and takes priority over a write.
module srg_ctrl
    import srg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      wr_data,
    output srg_mode_e mode_q
);

    srg_mode_e mode_d;

    // Next state from the register write port.
    always_comb begin
        mode_d = mode_q;
        if (wr_en) begin
            mode_d = wr_data ? SRG_RUN : SRG_SW_HOLD;
        end
    end

    // State register, system reset forces the system-hold state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SRG_SYS_HOLD;
        end else begin
            mode_q <= mode_d;
        end
    end

endmodule

// File: rtl/srg_clkdiv.sv
`timescale 1ns/1ps
// Module: srg_clkdiv
// Programmable bit-clock divider. While running, the counter steps
// through 0..div, and the registered output is high for the first
// floor((div+1)/2) counts (at least one). While held, the counter sits at
// zero. The output toggles every cycle in system hold and is low in
// software hold. The output lags the counter by one register stage.
// Assumes: div changes only while held (a live change is absorbed by the
// >= wrap compare).
module srg_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sys_hold,
    input  logic [DIV_W-1:0] div,
    output logic             wrap,
    output logic             clk_out
);

    localparam int RATIO_W = DIV_W + 1;

    logic [DIV_W-1:0]   cnt_q;
    logic [RATIO_W-1:0] ratio;
    logic [RATIO_W-1:0] high_len;
    logic               phase_high;

    // Ratio and length of the high phase, minimum one count.
    always_comb begin
        ratio    = {1'b0, div} + RATIO_W'(1);
        high_len = (div == '0) ? RATIO_W'(1) : (ratio >> 1);
    end

    // Current count lies inside the high phase.
    assign phase_high = ({1'b0, cnt_q} < high_len);

    // End of one bit-clock period while running.
    assign wrap = run && (cnt_q >= div);

    // Divider counter, cleared whenever the generator is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // Registered clock output: divided, half-rate, or low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_out <= 1'b0;
        end else if (run) begin
            clk_out <= phase_high;
        end else if (sys_hold) begin
            clk_out <= ~clk_out;
        end else begin
            clk_out <= 1'b0;
        end
    end

endmodule

// File: rtl/srg_frame.sv
`timescale 1ns/1ps
// Module: srg_frame
// Frame-sync generator. Counts bit-clock periods 0..per, advancing on the
// divider wrap. The registered pulse is high for the whole period at count
// zero while the enable input is high.
// Assumes: wrap comes from the divider in the same cycle as its count.
module srg_frame #(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wrap,
    input  logic             fs_en,
    input  logic [PER_W-1:0] per,
    output logic             fs_out
);

    logic [PER_W-1:0] fcnt_q;

    // Frame period counter, cleared while held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt_q <= '0;
        end else if (!run) begin
            fcnt_q <= '0;
        end else if (wrap) begin
            fcnt_q <= (fcnt_q >= per) ? '0 : fcnt_q + PER_W'(1);
        end
    end

    // Registered frame-sync pulse, gated by run and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_out <= 1'b0;
        end else begin
            fs_out <= run && fs_en && (fcnt_q == '0);
        end
    end

endmodule

// File: rtl/srg_top.sv
`timescale 1ns/1ps
// Module: srg_top
// Bit-clock and frame-sync generator with a negative-polarity run bit
// whose hold behaviour depends on the reset cause.
// Assumes: one clock domain; clk_div and frame_per are static while running.
module srg_top
    import srg_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_data,
    output logic             rd_data,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [PER_W-1:0] frame_per,
    input  logic             fs_en,
    output logic             clk_out,
    output logic             fs_out
);

    srg_mode_e mode_q;
    logic      run;
    logic      sys_hold;
    logic      wrap;

    // Decode of the state into datapath controls and read value.
    assign run      = (mode_q == SRG_RUN);
    assign sys_hold = (mode_q == SRG_SYS_HOLD);
    assign rd_data  = run;

    srg_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .mode_q  (mode_q)
    );

    srg_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sys_hold (sys_hold),
        .div      (clk_div),
        .wrap     (wrap),
        .clk_out  (clk_out)
    );

    srg_frame #(.PER_W(PER_W)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .wrap   (wrap),
        .fs_en  (fs_en),
        .per    (frame_per),
        .fs_out (fs_out)
    );

endmodule

// File: rtl/srg_chk.sv
`timescale 1ns/1ps
// Module: srg_chk
// Temporal checks for srg_top, attached by bind.
// Assumes: sampled on the system clock edge.
module srg_chk
    import srg_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      wr_en,
    input logic      wr_data,
    input logic      rd_data,
    input logic      fs_en,
    input logic      clk_out,
    input logic      fs_out,
    input srg_mode_e mode_q
);

    // R1: a sampled system reset clears the bit and both outputs.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!rd_data && !clk_out && !fs_out));

    // R2: the system-hold state gives a half-rate clock and no frame sync.
    a_r2_sys_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SRG_SYS_HOLD) |=> ((clk_out != $past(clk_out)) && !fs_out));

    // R3: the software-hold state drives both outputs low.
    a_r3_sw_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SRG_SW_HOLD) |=> (!clk_out && !fs_out));

    // R4: the first running cycle starts the high phase.
    a_r4_first_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == SRG_RUN) && !$past(mode_q == SRG_RUN)) |=> clk_out);

    // R6: frame sync only follows a running cycle.
    a_r6_fs_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        fs_out |-> $past(mode_q == SRG_RUN));

    // R7: a low enable suppresses frame sync on the next edge.
    a_r7_fs_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_en |=> !fs_out);

    // R8: writing 1 while running keeps the run state.
    a_r8_run_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == SRG_RUN) && wr_en && wr_data) |=> rd_data);

endmodule

bind srg_top srg_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .fs_en   (fs_en),
    .clk_out (clk_out),
    .fs_out  (fs_out),
    .mode_q  (mode_q)
);

// File: tb/sim_srg_top.sv
`timescale 1ns/1ps
// Bench: a reference model pushes one expected item per system clock edge
// into a queue; a monitor pops and compares it at the falling edge.
module sim_srg_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_data = 1'b0;
    logic        rd_data;
    logic [7:0]  clk_div = 8'd1;
    logic [11:0] frame_per = 12'd0;
    logic        fs_en = 1'b0;
    logic        clk_out;
    logic        fs_out;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    typedef struct {
        logic  c;
        logic  f;
        logic  r;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t got;

    always #2 clk = ~clk;

    srg_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .clk_div   (clk_div),
        .frame_per (frame_per),
        .fs_en     (fs_en),
        .clk_out   (clk_out),
        .fs_out    (fs_out)
    );

    // Reference model, written from the requirement formulas.
    // m_state: 0 system hold, 1 software hold, 2 run.
    int   m_state = 0;
    int   m_k = 0;
    logic m_clk = 1'b0;
    logic m_fs = 1'b0;

    always @(posedge clk) begin
        int old;
        int n;
        int h;
        exp_t e;
        if (!rst_n) begin
            m_state = 0;
            m_k = 0;
            m_clk = 1'b0;
            m_fs = 1'b0;
        end else begin
            old = m_state;
            if (wr_en) m_state = wr_data ? 2 : 1;
            if (old == 2) begin
                n = int'(clk_div) + 1;
                h = (n == 1) ? 1 : n / 2;
                m_clk = ((m_k % n) < h);
                m_fs = fs_en && (((m_k / n) % (int'(frame_per) + 1)) == 0);
                m_k = m_k + 1;
            end else begin
                m_k = 0;
                m_fs = 1'b0;
                m_clk = (old == 0) ? ~m_clk : 1'b0;
            end
        end
        e.c = m_clk;
        e.f = m_fs;
        e.r = (m_state == 2);
        e.tag = cur_tag;
        exp_q.push_back(e);
    end

    // Monitor: compare outputs with the oldest expected item.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            got = exp_q.pop_front();
            checks++;
            if (clk_out !== got.c || fs_out !== got.f || rd_data !== got.r) begin
                failures++;
                $display("FAIL %s t=%0t clk/fs/rd actual=%b%b%b expected=%b%b%b",
                         got.tag, $time, clk_out, fs_out, rd_data,
                         got.c, got.f, got.r);
            end
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_bit(input logic v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        cur_tag = "R1";
        wait_cycles(4);
        rst_n = 1'b1;
        cur_tag = "R2";
        wait_cycles(8);
        cur_tag = "R9";
        write_bit(1'b0);
        wait_cycles(6);
        // Even ratio N=4, frame every 3 periods.
        clk_div = 8'd3;
        frame_per = 12'd2;
        fs_en = 1'b1;
        cur_tag = "R4";
        write_bit(1'b1);
        cur_tag = "R6";
        wait_cycles(50);
        cur_tag = "R8";
        write_bit(1'b1);
        wait_cycles(30);
        cur_tag = "R7";
        fs_en = 1'b0;
        wait_cycles(24);
        fs_en = 1'b1;
        cur_tag = "R6";
        wait_cycles(24);
        cur_tag = "R3";
        write_bit(1'b0);
        wait_cycles(10);
        // Odd ratio N=5, frame every 2 periods.
        clk_div = 8'd4;
        frame_per = 12'd1;
        cur_tag = "R5";
        write_bit(1'b1);
        wait_cycles(40);
        write_bit(1'b0);
        // Ratio of one.
        clk_div = 8'd0;
        frame_per = 12'd3;
        write_bit(1'b1);
        wait_cycles(12);
        cur_tag = "R3";
        write_bit(1'b0);
        wait_cycles(4);
        // Frame period of one bit-clock period.
        clk_div = 8'd2;
        frame_per = 12'd0;
        cur_tag = "R10";
        write_bit(1'b1);
        wait_cycles(20);
        // System reset in the middle of a run.
        cur_tag = "R1";
        rst_n = 1'b0;
        wait_cycles(3);
        rst_n = 1'b1;
        cur_tag = "R2";
        wait_cycles(8);
        cur_tag = "R4";
        write_bit(1'b1);
        wait_cycles(12);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule